// File: doc/BRIEF.md
# Frame-Timed Color Bar Pattern Generator

This block is a programmable test-pattern source for camera data paths. It emits frames as byte bursts: each active line of a frame becomes one contiguous burst of a programmed number of payload bytes. Every burst carries a data-type code and markers for line start, line end, frame start and frame end. The payload is either a row of color bars, whose widths are a byte count and whose values come from a bank of fifteen color registers, or one fixed color across the whole line.

Line timing comes from a line-period counter, not from a pixel count. A line starts every `period` clock cycles. No horizontal blanking is sent, so once a line's bytes are out the output stays idle until the next line start. A frame has a programmed total number of lines, taken in this order: vertical sync lines, back-porch lines, active lines, front-porch lines. The sync length is whatever the total leaves after the active lines and both porches. Register writes land in live copies, which are moved into shadow copies only at frame boundaries.

Top module: `tpat_frame_gen`

## Requirements
- R1: After reset all outputs are low, including `out_valid`, every marker, `out_data`, `out_dt` and `cfg_err`.
- R2: Bit 0 of the control register (address 0x00) enables generation, and nothing is emitted while it is clear. Once it is set, the first byte of the first active line appears (sync + back porch) × period + 2 clock edges after the edge that accepts the write. Clearing the bit lets the current frame finish, and output then stops.
- R3: Each active line is one contiguous burst of exactly line-size bytes, with `out_valid` high throughout. The line size is a 16-bit value with its high byte at 0x03 and its low byte at 0x04. `out_sol` marks the first byte and `out_eol` the last. The output is idle in the cycle after `out_eol`, and no marker is ever high without `out_valid`.
- R4: Line starts are spaced exactly by the line period, a 16-bit value with its high byte at 0x0B and its low byte at 0x0C. The spacing does not depend on the line size.
- R5: The active lines per frame (high byte 0x07, low byte 0x08) are emitted as consecutive line periods. `out_sof` marks the first byte of the first active line and `out_eof` the last byte of the last active line. Frames repeat every total × period cycles; total lines uses high byte 0x09 and low byte 0x0A, back porch 0x0D, front porch 0x0E.
- R6: If total < active + back porch + front porch, the sync length becomes zero and a frame lasts (active + both porches) × period cycles. In that case `cfg_err` is set and stays set until reset.
- R7: When bit 7 of the configuration register (0x01) is 0, payload byte i equals color register k = min(floor(i / bar size), 14). Color register k sits at address 0x10 + k. The bar size is a 16-bit byte count, with its high byte at 0x05 and its low byte at 0x06.
- R8: When bit 7 of 0x01 is 1, every payload byte equals color register 0 (0x10).
- R9: `out_dt` equals the data-type register (0x02) on every valid byte.
- R10: A register write made during a frame changes nothing in that frame and takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_dt | output | 8 | Data-type code of the current line |
| out_sol | output | 1 | First byte of a line |
| out_eol | output | 1 | Last byte of a line |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| cfg_err | output | 1 | Sticky vertical-timing error |

## Verification
Two pairs of events can land in the same cycle. With a one-byte line and one active line, the line-start, line-end, frame-start and frame-end markers all fall on a single byte. The bench sets up exactly that case and requires all four markers on the one byte, with the right fixed color value. A register write can also land on the frame-boundary shadow load. The bench provokes this by rewriting the line size and the pattern mode in the middle of a frame. It then requires the remaining lines of that frame to keep their old length and bar data, and the following frame to use the new length and the fixed color.

// File: rtl/tpat_pkg.sv
// Shared constants for the frame-timed pattern generator: register
// addresses and field widths. Assumes byte-wide register writes.
package tpat_pkg;
    localparam int NUM_COLORS = 15;
    localparam int BYTE_W     = 8;

    localparam int A_CTRL   = 0;
    localparam int A_CFG    = 1;
    localparam int A_DT     = 2;
    localparam int A_LSZ_H  = 3;
    localparam int A_LSZ_L  = 4;
    localparam int A_BAR_H  = 5;
    localparam int A_BAR_L  = 6;
    localparam int A_ACT_H  = 7;
    localparam int A_ACT_L  = 8;
    localparam int A_TOT_H  = 9;
    localparam int A_TOT_L  = 10;
    localparam int A_PER_H  = 11;
    localparam int A_PER_L  = 12;
    localparam int A_VBP    = 13;
    localparam int A_VFP    = 14;
    localparam int A_COLOR0 = 16;
endpackage

// File: rtl/tpat_regs.sv
// Register bank: live copies written by the byte port, shadow copies
// captured on 'load' (frame boundary). Assumes one write per cycle.
module tpat_regs
    import tpat_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int LINE_W  = 16,
    parameter int PORCH_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [BYTE_W-1:0]                 wr_data,
    input  logic                              load,
    output logic                              live_en,
    output logic                              shd_fixed,
    output logic [BYTE_W-1:0]                 shd_dt,
    output logic [LINE_W-1:0]                 shd_line_size,
    output logic [LINE_W-1:0]                 shd_bar_size,
    output logic [LINE_W-1:0]                 shd_act,
    output logic [LINE_W-1:0]                 shd_tot,
    output logic [LINE_W-1:0]                 shd_per,
    output logic [PORCH_W-1:0]                shd_vbp,
    output logic [PORCH_W-1:0]                shd_vfp,
    output logic [NUM_COLORS-1:0][BYTE_W-1:0] shd_color
);
    localparam int HI_W = LINE_W - BYTE_W;

    logic                 fixed_q;
    logic [BYTE_W-1:0]    dt_q;
    logic [LINE_W-1:0]    lsz_q, bar_q, act_q, tot_q, per_q;
    logic [PORCH_W-1:0]   vbp_q, vfp_q;

    // Live control and timing registers written from the byte port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_en <= 1'b0;
            fixed_q <= 1'b0;
            dt_q    <= '0;
            lsz_q   <= '0;
            bar_q   <= '0;
            act_q   <= '0;
            tot_q   <= '0;
            per_q   <= '0;
            vbp_q   <= '0;
            vfp_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CTRL))  live_en <= wr_data[0];
            if (wr_addr == ADDR_W'(A_CFG))   fixed_q <= wr_data[7];
            if (wr_addr == ADDR_W'(A_DT))    dt_q    <= wr_data;
            if (wr_addr == ADDR_W'(A_LSZ_H)) lsz_q[LINE_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            if (wr_addr == ADDR_W'(A_LSZ_L)) lsz_q[BYTE_W-1:0]      <= wr_data;
            if (wr_addr == ADDR_W'(A_BAR_H)) bar_q[LINE_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            if (wr_addr == ADDR_W'(A_BAR_L)) bar_q[BYTE_W-1:0]      <= wr_data;
            if (wr_addr == ADDR_W'(A_ACT_H)) act_q[LINE_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            if (wr_addr == ADDR_W'(A_ACT_L)) act_q[BYTE_W-1:0]      <= wr_data;
            if (wr_addr == ADDR_W'(A_TOT_H)) tot_q[LINE_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            if (wr_addr == ADDR_W'(A_TOT_L)) tot_q[BYTE_W-1:0]      <= wr_data;
            if (wr_addr == ADDR_W'(A_PER_H)) per_q[LINE_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            if (wr_addr == ADDR_W'(A_PER_L)) per_q[BYTE_W-1:0]      <= wr_data;
            if (wr_addr == ADDR_W'(A_VBP))   vbp_q   <= wr_data[PORCH_W-1:0];
            if (wr_addr == ADDR_W'(A_VFP))   vfp_q   <= wr_data[PORCH_W-1:0];
        end
    end

    // Shadow copies of control and timing fields, refreshed at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_fixed     <= 1'b0;
            shd_dt        <= '0;
            shd_line_size <= '0;
            shd_bar_size  <= '0;
            shd_act       <= '0;
            shd_tot       <= '0;
            shd_per       <= '0;
            shd_vbp       <= '0;
            shd_vfp       <= '0;
        end else if (load) begin
            shd_fixed     <= fixed_q;
            shd_dt        <= dt_q;
            shd_line_size <= lsz_q;
            shd_bar_size  <= bar_q;
            shd_act       <= act_q;
            shd_tot       <= tot_q;
            shd_per       <= per_q;
            shd_vbp       <= vbp_q;
            shd_vfp       <= vfp_q;
        end
    end

    // One live/shadow pair per color register.
    for (genvar k = 0; k < NUM_COLORS; k++) begin : g_color
        logic [BYTE_W-1:0] live_q, shd_q;
        // Live color write and shadow capture for color k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
                shd_q  <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(A_COLOR0 + k)) live_q <= wr_data;
                if (load) shd_q <= live_q;
            end
        end
        assign shd_color[k] = shd_q;
    end
endmodule

// File: rtl/tpat_timing.sv
// Vertical/line timing: a line-period counter and a line counter.
// Line order within a frame: sync, back porch, active, front porch.
// Sync is clamped at zero when the total is too small (sticky error).
// Assumes shadow timing fields stay stable between frame boundaries.
module tpat_timing #(
    parameter int LINE_W  = 16,
    parameter int PORCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               live_en,
    input  logic [LINE_W-1:0]  act_lines,
    input  logic [LINE_W-1:0]  tot_lines,
    input  logic [LINE_W-1:0]  line_per,
    input  logic [PORCH_W-1:0] vbp,
    input  logic [PORCH_W-1:0] vfp,
    output logic               load,
    output logic               line_start,
    output logic               first_act,
    output logic               last_act,
    output logic               cfg_err
);
    localparam int LW1 = LINE_W + 1;

    logic              running;
    logic [LINE_W-1:0] pcnt;
    logic [LW1-1:0]    lcnt;
    logic [LW1-1:0]    sum, sync_len, tot_eff, act_lo, act_hi;
    logic [LINE_W-1:0] per_eff;
    logic              clamp, per_last, frame_end;

    // Derived frame geometry from the shadow fields.
    always_comb begin
        sum      = LW1'(act_lines) + LW1'(vbp) + LW1'(vfp);
        clamp    = LW1'(tot_lines) < sum;
        sync_len = clamp ? '0 : LW1'(tot_lines) - sum;
        tot_eff  = clamp ? sum : LW1'(tot_lines);
        if (tot_eff == '0) tot_eff = LW1'(1);
        per_eff  = (line_per == '0) ? LINE_W'(1) : line_per;
        act_lo   = sync_len + LW1'(vbp);
        act_hi   = act_lo + LW1'(act_lines);
    end

    assign per_last   = pcnt == per_eff - LINE_W'(1);
    assign frame_end  = running && per_last && (lcnt == tot_eff - LW1'(1));
    assign load       = (!running && live_en) || frame_end;
    assign line_start = running && (pcnt == '0) && (lcnt >= act_lo) && (lcnt < act_hi);
    assign first_act  = lcnt == act_lo;
    assign last_act   = lcnt == act_hi - LW1'(1);

    // Run state, period counter and line counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pcnt    <= '0;
            lcnt    <= '0;
        end else if (!running) begin
            running <= live_en;
            pcnt    <= '0;
            lcnt    <= '0;
        end else if (frame_end) begin
            running <= live_en;
            pcnt    <= '0;
            lcnt    <= '0;
        end else if (per_last) begin
            pcnt    <= '0;
            lcnt    <= lcnt + LW1'(1);
        end else begin
            pcnt    <= pcnt + LINE_W'(1);
        end
    end

    // Sticky flag for a total that cannot hold active lines and porches.
    always_ff @(posedge clk) begin
        if (!rst_n)                cfg_err <= 1'b0;
        else if (running && clamp) cfg_err <= 1'b1;
    end
endmodule

// File: rtl/tpat_payload.sv
// Line burst engine: on a line start, emits line_size contiguous bytes
// with bar or fixed color values and line/frame markers.
// Assumes line_size is smaller than the line period.
module tpat_payload
    import tpat_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              first_act,
    input  logic                              last_act,
    input  logic                              fixed_mode,
    input  logic [BYTE_W-1:0]                 dt,
    input  logic [LINE_W-1:0]                 line_size,
    input  logic [LINE_W-1:0]                 bar_size,
    input  logic [NUM_COLORS-1:0][BYTE_W-1:0] color,
    output logic                              out_valid,
    output logic [BYTE_W-1:0]                 out_data,
    output logic [BYTE_W-1:0]                 out_dt,
    output logic                              out_sol,
    output logic                              out_eol,
    output logic                              out_sof,
    output logic                              out_eof
);
    localparam int CW = $clog2(NUM_COLORS);

    logic              busy, f_flag, l_flag;
    logic [LINE_W-1:0] cnt, bar_cnt, bar_eff;
    logic [CW-1:0]     bar_idx;
    logic              is_last;

    assign bar_eff = (bar_size == '0) ? LINE_W'(1) : bar_size;
    assign is_last = cnt == line_size - LINE_W'(1);

    // Burst progress, byte counter and saturating bar index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            bar_cnt <= '0;
            bar_idx <= '0;
            f_flag  <= 1'b0;
            l_flag  <= 1'b0;
        end else if (start && line_size != '0) begin
            busy    <= 1'b1;
            cnt     <= '0;
            bar_cnt <= '0;
            bar_idx <= '0;
            f_flag  <= first_act;
            l_flag  <= last_act;
        end else if (busy) begin
            if (is_last) busy <= 1'b0;
            cnt <= cnt + LINE_W'(1);
            if (bar_cnt == bar_eff - LINE_W'(1)) begin
                bar_cnt <= '0;
                if (bar_idx != CW'(NUM_COLORS - 1)) bar_idx <= bar_idx + CW'(1);
            end else begin
                bar_cnt <= bar_cnt + LINE_W'(1);
            end
        end
    end

    // Byte value: fixed color 0 or the current bar's color.
    always_comb begin
        out_data = '0;
        if (busy) begin
            if (fixed_mode) out_data = color[0];
            else begin
                for (int k = 0; k < NUM_COLORS; k++)
                    if (bar_idx == CW'(k)) out_data = color[k];
            end
        end
    end

    assign out_valid = busy;
    assign out_dt    = busy ? dt : '0;
    assign out_sol   = busy && (cnt == '0);
    assign out_eol   = busy && is_last;
    assign out_sof   = out_sol && f_flag;
    assign out_eof   = out_eol && l_flag;
endmodule

// File: rtl/tpat_frame_gen.sv
// Top of the frame-timed pattern generator: register bank, line
// timing and burst engine. Assumes wr_* are synchronous to clk.
module tpat_frame_gen
    import tpat_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int LINE_W  = 16,
    parameter int PORCH_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]  wr_data,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic [7:0]  out_dt,
    output logic        out_sol,
    output logic        out_eol,
    output logic        out_sof,
    output logic        out_eof,
    output logic        cfg_err
);
    logic                              live_en, load, line_start, first_act, last_act;
    logic                              shd_fixed;
    logic [BYTE_W-1:0]                 shd_dt;
    logic [LINE_W-1:0]                 shd_line_size, shd_bar_size, shd_act, shd_tot, shd_per;
    logic [PORCH_W-1:0]                shd_vbp, shd_vfp;
    logic [NUM_COLORS-1:0][BYTE_W-1:0] shd_color;

    tpat_regs #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .PORCH_W(PORCH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load(load), .live_en(live_en), .shd_fixed(shd_fixed), .shd_dt(shd_dt),
        .shd_line_size(shd_line_size), .shd_bar_size(shd_bar_size), .shd_act(shd_act),
        .shd_tot(shd_tot), .shd_per(shd_per), .shd_vbp(shd_vbp), .shd_vfp(shd_vfp),
        .shd_color(shd_color)
    );

    tpat_timing #(.LINE_W(LINE_W), .PORCH_W(PORCH_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .live_en(live_en), .act_lines(shd_act),
        .tot_lines(shd_tot), .line_per(shd_per), .vbp(shd_vbp), .vfp(shd_vfp),
        .load(load), .line_start(line_start), .first_act(first_act),
        .last_act(last_act), .cfg_err(cfg_err)
    );

    tpat_payload #(.LINE_W(LINE_W)) u_payload (
        .clk(clk), .rst_n(rst_n), .start(line_start), .first_act(first_act),
        .last_act(last_act), .fixed_mode(shd_fixed), .dt(shd_dt),
        .line_size(shd_line_size), .bar_size(shd_bar_size), .color(shd_color),
        .out_valid(out_valid), .out_data(out_data), .out_dt(out_dt),
        .out_sol(out_sol), .out_eol(out_eol), .out_sof(out_sof), .out_eof(out_eof)
    );
endmodule

// File: rtl/tpat_checker.sv
// Protocol checker for the pattern generator outputs, bound to the top.
module tpat_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic [7:0] out_dt,
    input logic       out_sol,
    input logic       out_eol,
    input logic       out_sof,
    input logic       out_eof,
    input logic       cfg_err
);
    assert_sof_on_sol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_sol));
    assert_eof_on_eol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (out_valid && out_eol));
    assert_burst_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eol) |=> (out_valid && !out_sol));
    assert_idle_after_eol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eol) |=> !out_valid);
    assert_markers_need_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_sol || out_eol || out_sof || out_eof));
    assert_dt_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eol) |=> $stable(out_dt));
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind tpat_frame_gen tpat_checker u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_dt(out_dt),
    .out_sol(out_sol), .out_eol(out_eol), .out_sof(out_sof),
    .out_eof(out_eof), .cfg_err(cfg_err)
);

// File: tb/tb_tpat_frame_gen.sv
`timescale 1ns/1ps
module tb_tpat_frame_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_valid, out_sol, out_eol, out_sof, out_eof, cfg_err;
    logic [7:0] out_data, out_dt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wr_cyc = 0;
    bit done = 0;

    // line capture results
    int         ln_len, ln_cyc;
    bit         ln_sof, ln_eof, ln_idle;
    logic [7:0] ln_dt;
    logic [7:0] ln_buf [64];

    tpat_frame_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data), .out_dt(out_dt),
        .out_sol(out_sol), .out_eol(out_eol), .out_sof(out_sof), .out_eof(out_eof),
        .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1;
        wr_addr = 5'(a);
        wr_data = 8'(d);
        @(posedge clk);
        #1;
        wr_cyc = cyc;
        wr_en = 1'b0;
    endtask

    task automatic setup(input int fixed, input int dt, input int lsz, input int bar,
                         input int act, input int tot, input int per,
                         input int vbp, input int vfp, input int cbase);
        wr(1, fixed ? 8'h80 : 8'h00);
        wr(2, dt);
        wr(3, lsz >> 8);  wr(4, lsz & 255);
        wr(5, bar >> 8);  wr(6, bar & 255);
        wr(7, act >> 8);  wr(8, act & 255);
        wr(9, tot >> 8);  wr(10, tot & 255);
        wr(11, per >> 8); wr(12, per & 255);
        wr(13, vbp);      wr(14, vfp);
        for (int k = 0; k < 15; k++) wr(16 + k, (cbase + k) & 255);
    endtask

    // Wait for a line start, collect its bytes, then sample the following cycle.
    task automatic get_line();
        int to = 0;
        ln_len = 0; ln_sof = 0; ln_eof = 0; ln_idle = 0;
        @(negedge clk);
        while (!(out_valid && out_sol) && to < 5000) begin
            @(negedge clk);
            to++;
        end
        if (to >= 5000) begin
            chk("R3", "line start timeout", 0, 1);
            return;
        end
        ln_cyc = cyc;
        ln_sof = out_sof;
        ln_dt  = out_dt;
        while (1) begin
            if (!out_valid) break;
            if (ln_len < 64) ln_buf[ln_len] = out_data;
            ln_len++;
            if (out_eof) ln_eof = 1;
            if (out_eol) break;
            @(negedge clk);
        end
        @(negedge clk);
        ln_idle = !out_valid;
    endtask

    task automatic count_valid(input int n, output int v);
        v = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) v++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "valid after reset", out_valid, 0);
        chk("R1", "markers after reset", {out_sol, out_eol, out_sof, out_eof}, 0);
        chk("R1", "data/dt after reset", {out_data, out_dt}, 0);
        chk("R1", "cfg_err after reset", cfg_err, 0);
    endtask

    task automatic t_enable();
        int v;
        int c0;
        do_reset();
        setup(0, 8'h2F, 4, 2, 2, 8, 12, 1, 2, 8'h10);
        count_valid(300, v);
        chk("R2", "bytes while disabled", v, 0);
        wr(0, 1);
        c0 = wr_cyc;
        get_line();
        chk("R2", "first frame start latency", ln_cyc - c0, 4 * 12 + 2);
        chk("R2", "first line has sof", ln_sof, 1);
    endtask

    task automatic t_bars();
        int c1, cf;
        do_reset();
        setup(0, 8'h2F, 10, 3, 3, 10, 20, 2, 1, 8'hA0);
        wr(0, 1);
        get_line();
        cf = ln_cyc;
        c1 = ln_cyc;
        chk("R3", "line length", ln_len, 10);
        chk("R3", "idle after eol", ln_idle, 1);
        chk("R5", "sof on first active line", ln_sof, 1);
        chk("R9", "data type", ln_dt, 8'h2F);
        for (int i = 0; i < 10; i++)
            chk("R7", $sformatf("bar byte %0d", i), ln_buf[i], 8'hA0 + (i / 3));
        get_line();
        chk("R4", "line spacing", ln_cyc - c1, 20);
        chk("R5", "middle line no sof/eof", ln_sof + ln_eof, 0);
        get_line();
        chk("R5", "eof on third active line", ln_eof, 1);
        get_line();
        chk("R5", "next frame sof", ln_sof, 1);
        chk("R5", "frame period", ln_cyc - cf, 10 * 20);
        chk("R6", "no error for valid total", cfg_err, 0);
    endtask

    task automatic t_single();
        int c1;
        do_reset();
        setup(1, 8'h24, 1, 1, 1, 4, 6, 0, 0, 8'h5A);
        wr(0, 1);
        get_line();
        c1 = ln_cyc;
        chk("R3", "one-byte line length", ln_len, 1);
        chk("R8", "fixed color byte", ln_buf[0], 8'h5A);
        chk("R5", "sof and eof on one byte", {ln_sof, ln_eof}, 2'b11);
        chk("R9", "data type 0x24", ln_dt, 8'h24);
        get_line();
        chk("R5", "frame period one active line", ln_cyc - c1, 4 * 6);
    endtask

    task automatic t_clamp();
        int c0, c1, v;
        do_reset();
        setup(0, 8'h2F, 4, 4, 3, 4, 10, 2, 1, 8'h20);
        wr(0, 1);
        c0 = wr_cyc;
        get_line();
        c1 = ln_cyc;
        chk("R6", "clamped sync start latency", ln_cyc - c0, 2 * 10 + 2);
        chk("R6", "cfg_err set", cfg_err, 1);
        get_line(); get_line(); get_line();
        chk("R6", "clamped frame sof", ln_sof, 1);
        chk("R6", "clamped frame period", ln_cyc - c1, 6 * 10);
        wr(9, 0); wr(10, 20);
        count_valid(500, v);
        chk("R6", "cfg_err sticky", cfg_err, 1);
    endtask

    task automatic t_saturate();
        int e;
        do_reset();
        setup(0, 8'h2F, 20, 1, 1, 3, 30, 0, 0, 8'h40);
        wr(0, 1);
        get_line();
        chk("R3", "long line length", ln_len, 20);
        for (int i = 0; i < 20; i++) begin
            e = 8'h40 + ((i > 14) ? 14 : i);
            chk("R7", $sformatf("saturated bar byte %0d", i), ln_buf[i], e);
        end
    endtask

    task automatic t_shadow();
        do_reset();
        setup(0, 8'h2F, 8, 2, 4, 6, 30, 1, 1, 8'h80);
        wr(0, 1);
        get_line();
        chk("R10", "first line sof", ln_sof, 1);
        wr(4, 5);
        wr(1, 8'h80);
        for (int l = 0; l < 3; l++) begin
            get_line();
            chk("R10", "old length kept in frame", ln_len, 8);
            chk("R10", "old bar data kept in frame", ln_buf[2], 8'h81);
        end
        get_line();
        chk("R10", "new frame sof", ln_sof, 1);
        chk("R10", "new length next frame", ln_len, 5);
        for (int i = 0; i < 5; i++)
            chk("R8", $sformatf("fixed byte %0d", i), ln_buf[i], 8'h80);
    endtask

    task automatic t_stop();
        int v;
        do_reset();
        setup(0, 8'h2F, 3, 1, 2, 4, 10, 0, 0, 8'h60);
        wr(0, 1);
        get_line();
        chk("R2", "running frame sof", ln_sof, 1);
        wr(0, 0);
        get_line();
        chk("R2", "frame finishes after disable", {ln_eof, 8'(ln_len)}, {1'b1, 8'd3});
        count_valid(200, v);
        chk("R2", "no bytes after stop", v, 0);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_bars();
        t_single();
        t_clamp();
        t_saturate();
        t_shadow();
        t_stop();
        done = 1;
        summary();
        $finish;
    end
endmodule